// File: doc/BRIEF.md
# Synchronous Memory Byte-Write and Data-Direction Control

This block is the write and output-direction stage of a flow-through synchronous memory with a 32-bit data path split into four byte lanes. An access starts with one of two address strobes: a processor strobe or a controller strobe. The strobe captures the externally generated address. In each cycle that may write, the block turns an all-lanes write enable, a byte write enable and four per-lane selects into byte strobes for a small parametrized storage array.

Read data comes straight from the array at the captured address. It is therefore valid in the cycle after the capturing clock edge, with no output register. The data path stays split into separate in and out buses with a drive qualifier, so no bidirectional port is needed. The drive qualifier follows an asynchronous output enable, drops whenever a write is detected and stays low while a sleep input is high. Sleep freezes all activity and keeps the stored contents.

Top module: `ssram_bw_io`

## Requirements
- R1: With `all_wr_ni` low in a cycle that may write, all four lanes are written, whatever `byte_wr_ni` and `byte_sel_ni` hold; `wr_be_o` reads 4'b1111.
- R2: With `all_wr_ni` high, lane i (data bits 8i+7..8i) is written only when `byte_wr_ni` is low and `byte_sel_ni[i]` is low; `wr_be_o[i]` is the strobe of lane i. With `byte_wr_ni` high, nothing is written.
- R3: In the cycle a processor strobe (`proc_stb_ni` low with `chip_en_i` high) is taken, the write inputs are ignored. In the following cycles, active write inputs write `wdata_i` to the captured address.
- R4: A controller strobe (`ctrl_stb_ni` low, `chip_en_i` high) with active write inputs writes `wdata_i` to the presented `addr_i` in that same cycle. With the write inputs inactive, it is a read of that address.
- R5: When both strobes are low with `chip_en_i` high, only the processor strobe is recognised, so the write inputs in that cycle have no effect.
- R6: During the cycle after an address is captured, `rdata_o` shows the stored word at that address (flow-through timing).
- R7: `drive_o` is low at once, with no clock edge, whenever `oe_ni` is high. It is high when `oe_ni` is low, a session is open, no write is in progress and sleep is inactive.
- R8: `drive_o` is low in any cycle where `wr_be_o` is nonzero, even with `oe_ni` low.
- R9: While `sleep_i` is high, no strobe is taken, nothing is written, `drive_o` is low, and the captured address and stored data are kept.
- R10: A processor strobe with `chip_en_i` low is ignored, and the captured address is kept. A controller strobe with `chip_en_i` low closes the session, and no write or drive follows until a new strobe.
- R11: After reset, no session is open: `drive_o` and `wr_be_o` stay low until a strobe is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Combined chip select, active high |
| proc_stb_ni | input | 1 | Processor address strobe, active low |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low |
| all_wr_ni | input | 1 | Write all lanes, active low |
| byte_wr_ni | input | 1 | Byte write enable, active low |
| byte_sel_ni | input | 4 | Per-lane select, active low, bit i for lane i |
| addr_i | input | ADDR_W | Word address from the external generator |
| wdata_i | input | 32 | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| rdata_o | output | 32 | Read data at the captured address |
| drive_o | output | 1 | High when the pad may drive `rdata_o` |
| wr_be_o | output | 4 | Byte strobes applied in the current cycle |

## Verification
The hardest state to reach is a detected write that must override an enabled output while a session is open. This needs a strobe cycle followed by a write cycle with `oe_ni` held low. The stimulus opens a session with each strobe type and asserts the write inputs only in the cycle under test, so the drive qualifier can be observed against both rules. The quieter conditions are reached by the same direct sequencing. These are the strobe cycle whose writes must vanish, the both-strobes collision, and sleep and deselect in the middle of a session. Each is then followed by a plain read, so that an unwanted write or a moved address shows up on `rdata_o`.

// File: rtl/ssram_bw_pkg.sv
package ssram_bw_pkg;
  typedef enum logic [1:0] {
    STB_NONE  = 2'd0,
    STB_PROC  = 2'd1,
    STB_CTRL  = 2'd2,
    STB_DESEL = 2'd3
  } stb_kind_e;
endpackage

// File: rtl/ssram_bw_decode.sv
module ssram_bw_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_ok_i,
  input  logic             all_wr_ni,
  input  logic             byte_wr_ni,
  input  logic [LANES-1:0] byte_sel_ni,
  output logic [LANES-1:0] be_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // global write overrides the per-lane path
    assign be_o[i] = wr_ok_i & (~all_wr_ni | (~byte_wr_ni & ~byte_sel_ni[i]));
  end
endmodule

// File: rtl/ssram_bw_access.sv
module ssram_bw_access
  import ssram_bw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              proc_stb_ni,
  input  logic              ctrl_stb_ni,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              sess_o,
  output logic              wr_ok_o
);
  stb_kind_e         kind;
  logic [ADDR_W-1:0] addr_q;
  logic              sess_q;

  always_comb begin
    if (sleep_i)                        kind = STB_NONE;
    else if (!proc_stb_ni && chip_en_i) kind = STB_PROC;
    else if (!ctrl_stb_ni)              kind = chip_en_i ? STB_CTRL : STB_DESEL;
    else                                kind = STB_NONE;
  end

  // processor-strobe cycle never writes; controller strobe writes at the new address
  assign wr_ok_o   = (kind == STB_CTRL) | ((kind == STB_NONE) & sess_q & ~sleep_i);
  assign wr_addr_o = (kind == STB_CTRL) ? addr_i : addr_q;
  assign addr_q_o  = addr_q;
  assign sess_o    = sess_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sess_q <= 1'b0;
    end else begin
      unique case (kind)
        STB_PROC, STB_CTRL: begin
          addr_q <= addr_i;
          sess_q <= 1'b1;
        end
        STB_DESEL: sess_q <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ssram_bw_array.sv
module ssram_bw_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (be_i[i]) mem[waddr_i] <= wdata_i[i*LANE_W +: LANE_W];
    end
    assign rdata_o[i*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/ssram_bw_io.sv
module ssram_bw_io #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              proc_stb_ni,
  input  logic              ctrl_stb_ni,
  input  logic              all_wr_ni,
  input  logic              byte_wr_ni,
  input  logic [LANES-1:0]  byte_sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o,
  output logic [LANES-1:0]  wr_be_o
);
  logic [ADDR_W-1:0] addr_q, wr_addr;
  logic              sess, wr_ok;
  logic [LANES-1:0]  be;

  ssram_bw_access #(.ADDR_W(ADDR_W)) u_access (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chip_en_i   (chip_en_i),
    .proc_stb_ni (proc_stb_ni),
    .ctrl_stb_ni (ctrl_stb_ni),
    .sleep_i     (sleep_i),
    .addr_i      (addr_i),
    .addr_q_o    (addr_q),
    .wr_addr_o   (wr_addr),
    .sess_o      (sess),
    .wr_ok_o     (wr_ok)
  );

  ssram_bw_decode #(.LANES(LANES)) u_decode (
    .wr_ok_i     (wr_ok),
    .all_wr_ni   (all_wr_ni),
    .byte_wr_ni  (byte_wr_ni),
    .byte_sel_ni (byte_sel_ni),
    .be_o        (be)
  );

  ssram_bw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .be_i    (be),
    .waddr_i (wr_addr),
    .wdata_i (wdata_i),
    .raddr_i (addr_q),
    .rdata_o (rdata_o)
  );

  // any detected write forces tristate regardless of oe_ni
  assign drive_o = ~oe_ni & sess & ~sleep_i & ~(|be);
  assign wr_be_o = be;
endmodule

// File: rtl/ssram_bw_io_chk.sv
module ssram_bw_io_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_en_i,
  input logic             proc_stb_ni,
  input logic             ctrl_stb_ni,
  input logic             all_wr_ni,
  input logic             oe_ni,
  input logic             sleep_i,
  input logic             drive_o,
  input logic [LANES-1:0] wr_be_o
);
  AST_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!all_wr_ni && (|wr_be_o)) |-> (&wr_be_o)); // R1
  AST_PROC_FIRST_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_stb_ni && chip_en_i) |-> (wr_be_o == '0)); // R3
  AST_OE_HIGH_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o); // R7
  AST_WR_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_be_o) |-> !drive_o); // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!drive_o && wr_be_o == '0)); // R9
  AST_DESEL_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_stb_ni && !chip_en_i && !sleep_i && !(proc_stb_ni == 1'b0 && chip_en_i))
      |=> (!drive_o && wr_be_o == '0)); // R10
endmodule

bind ssram_bw_io ssram_bw_io_chk #(.LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_en_i   (chip_en_i),
  .proc_stb_ni (proc_stb_ni),
  .ctrl_stb_ni (ctrl_stb_ni),
  .all_wr_ni   (all_wr_ni),
  .oe_ni       (oe_ni),
  .sleep_i     (sleep_i),
  .drive_o     (drive_o),
  .wr_be_o     (wr_be_o)
);

// File: tb/tb_ssram_bw_io.sv
module tb_ssram_bw_io;
  logic        clk = 1'b0;
  logic        rst_ni, chip_en, proc_n, ctrl_n, gw_n, bwe_n, oe_n, sleep;
  logic [3:0]  bsel_n;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        drive;
  logic [3:0]  be;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  ssram_bw_io dut (
    .clk_i(clk), .rst_ni(rst_ni), .chip_en_i(chip_en), .proc_stb_ni(proc_n),
    .ctrl_stb_ni(ctrl_n), .all_wr_ni(gw_n), .byte_wr_ni(bwe_n), .byte_sel_ni(bsel_n),
    .addr_i(addr), .wdata_i(wdata), .oe_ni(oe_n), .sleep_i(sleep),
    .rdata_o(rdata), .drive_o(drive), .wr_be_o(be)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    chip_en = 1; proc_n = 1; ctrl_n = 1; gw_n = 1; bwe_n = 1;
    bsel_n = 4'hF; oe_n = 0; sleep = 0; wdata = '0;
  endtask

  task automatic nx();
    @(negedge clk); idle();
  endtask

  task automatic wr_ctrl(logic [5:0] a, logic [31:0] d);
    nx(); ctrl_n = 0; addr = a; gw_n = 0; wdata = d;
  endtask

  task automatic t_reset();
    rst_ni = 0; idle(); addr = '0; gw_n = 0;
    repeat (3) @(negedge clk);
    #1 chk("R11 drive in reset", 32'(drive), 0);
    chk("R11 be in reset", 32'(be), 0);
    rst_ni = 1;
    nx(); #1 chk("R11 no session drive", 32'(drive), 0);
  endtask

  task automatic t_proc_write();
    nx(); proc_n = 0; addr = 5; gw_n = 0; wdata = 32'hFFFF_FFFF;
    #1 chk("R3 strobe cycle be", 32'(be), 0);
    nx(); gw_n = 0; wdata = 32'h1122_3344;
    #1 chk("R1 all lanes", 32'(be), 32'hF);
    chk("R8 tristate on write", 32'(drive), 0);
    nx(); #1 chk("R6 read after write", rdata, 32'h1122_3344);
    chk("R7 drive enabled", 32'(drive), 1);
  endtask

  task automatic t_byte();
    nx(); proc_n = 0; addr = 7;
    nx(); gw_n = 0; wdata = 0;
    nx(); bwe_n = 0; bsel_n = 4'b1010; wdata = 32'hAABB_CCDD;
    #1 chk("R2 lanes 0 and 2", 32'(be), 32'h5);
    nx(); bwe_n = 1; bsel_n = 4'b0000; wdata = 32'hFFFF_FFFF;
    #1 chk("R2 byte enable off", 32'(be), 0);
    nx(); gw_n = 0; bwe_n = 1; bsel_n = 4'hF; wdata = 32'h0000_00EE;
    #1 chk("R1 override selects", 32'(be), 32'hF);
    nx(); bwe_n = 0; bsel_n = 4'b0111; wdata = 32'h9900_0000;
    nx(); #1 chk("R2 merged word", rdata, 32'h9900_00EE);
  endtask

  task automatic t_proc_ignore();
    wr_ctrl(9, 0);
    nx(); proc_n = 0; addr = 9; gw_n = 0; wdata = 32'hDEAD_BEEF;
    #1 chk("R3 ignored be", 32'(be), 0);
    nx(); #1 chk("R3 data unchanged", rdata, 0);
  endtask

  task automatic t_ctrl();
    nx(); ctrl_n = 0; addr = 12; gw_n = 0; wdata = 32'hCAFE_F00D;
    #1 chk("R4 ctrl write be", 32'(be), 32'hF);
    chk("R8 ctrl write tristate", 32'(drive), 0);
    nx(); #1 chk("R4 ctrl write data", rdata, 32'hCAFE_F00D);
    nx(); ctrl_n = 0; addr = 9;
    #1 chk("R4 ctrl read no be", 32'(be), 0);
    nx(); #1 chk("R4 ctrl read data", rdata, 0);
  endtask

  task automatic t_priority();
    wr_ctrl(20, 1);
    nx(); proc_n = 0; ctrl_n = 0; addr = 20; gw_n = 0; wdata = 32'h77;
    #1 chk("R5 proc wins be", 32'(be), 0);
    nx(); #1 chk("R5 no write", rdata, 1);
  endtask

  task automatic t_oe();
    nx(); oe_n = 1;
    #1 chk("R7 oe high", 32'(drive), 0);
    oe_n = 0;
    #0.5 chk("R7 oe low async", 32'(drive), 1);
  endtask

  task automatic t_ce_low();
    nx(); proc_n = 0; chip_en = 0; addr = 12;
    nx(); #1 chk("R10 proc ignored", rdata, 1);
  endtask

  task automatic t_sleep();
    nx(); sleep = 1; ctrl_n = 0; addr = 12; gw_n = 0; wdata = 0;
    #1 chk("R9 sleep be", 32'(be), 0);
    chk("R9 sleep drive", 32'(drive), 0);
    nx(); sleep = 1; gw_n = 0;
    #1 chk("R9 sleep no write", 32'(be), 0);
    nx(); #1 chk("R9 address kept", rdata, 1);
    chk("R9 drive back", 32'(drive), 1);
    nx(); ctrl_n = 0; addr = 12;
    nx(); #1 chk("R9 contents kept", rdata, 32'hCAFE_F00D);
  endtask

  task automatic t_desel();
    nx(); ctrl_n = 0; chip_en = 0; gw_n = 0; wdata = 0;
    #1 chk("R10 deselect be", 32'(be), 0);
    nx(); gw_n = 0; wdata = 0;
    #1 chk("R10 closed no be", 32'(be), 0);
    chk("R10 closed no drive", 32'(drive), 0);
    nx(); ctrl_n = 0; addr = 12;
    nx(); #1 chk("R10 no stray write", rdata, 32'hCAFE_F00D);
  endtask

  initial begin
    t_reset();
    t_proc_write();
    t_byte();
    t_proc_ignore();
    t_ctrl();
    t_priority();
    t_oe();
    t_ce_low();
    t_sleep();
    t_desel();
    nx();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule